// File: doc/BRIEF.md
# Transponder Frame Decoder

This block sits behind the reader's demodulator and turns a stream of already decoded bits into identification codes. Each bit comes with a one-cycle valid strobe. The strobes may arrive in consecutive cycles or with idle cycles between them.

While searching, the decoder counts consecutive 1 bits. A run of the header length marks the start of a frame, because the parity layout keeps any such run out of the body. The body is organised as follows:

- Ten groups follow the header. Each group holds four data bits and one even parity bit.
- Four even column parity bits come next.
- A single stop bit ends the frame.

The decoder checks each parity bit as soon as it arrives. It drops the frame on the first failed check and returns to header search. A frame that passes every check produces the 40-bit code and a one-cycle valid pulse.

An optional confirm mode holds back a code until two consecutive good frames carry the same value.

Top module: `fd_frame_decoder`

## Requirements
- R1: While rst_ni is low, and after it is released, id_valid_o and parity_err_o are 0 and id_o is all zeros.
- R2: Header search counts strobed 1 bits and locks on the 9th consecutive one. A strobed 0 clears the count, so a run of 8 ones followed by a 0 never locks.
- R3: After the header, 10 groups arrive, each made of 4 data bits followed by an even parity bit. The first data bit received lands in id_o[39] and the last in id_o[0]. Bits 39:32 carry the version field and bits 31:0 carry the serial number.
- R4: When a group parity bit mismatches, parity_err_o goes high for one cycle, in the cycle right after that strobe. The frame is discarded and header search restarts.
- R5: Column parity bit c (c = 0..3, received in that order) is the even parity of data bit position c across all 10 groups. A mismatch pulses parity_err_o in the cycle after its strobe and drops the frame.
- R6: The stop bit must be 0. A stop bit of 1 pulses parity_err_o in the cycle after its strobe, and no code is reported.
- R7: id_valid_o pulses for exactly one cycle, in the cycle after the stop strobe of a frame that passed all checks. id_o keeps the last reported code until the next report.
- R8: Frames sent back to back, with each header directly after the previous stop bit, are each decoded.
- R9: Cycles with bit_valid_i low have no effect, whatever bit_i carries.
- R10: After any failure, the next clean frame in the stream is decoded and reported.
- R11: With confirm_i high, a good frame is reported only when it equals the previous good frame and no failure came between them. A failure clears the stored frame.
- R12: Starting in the middle of a frame, the decoder ignores the partial frame and reports the first complete frame that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_i | input | 1 | Demodulated data bit |
| bit_valid_i | input | 1 | One-cycle strobe qualifying bit_i |
| confirm_i | input | 1 | Report a code only after two identical frames in a row |
| id_o | output | 40 | Last reported code: version in [39:32], serial in [31:0] |
| id_valid_o | output | 1 | One-cycle pulse when id_o is updated |
| parity_err_o | output | 1 | One-cycle pulse on a failed row, column or stop check |

## Verification
The bench uses the default parameters: a 9-bit header, 10 rows and 4 columns, which gives the full 64-bit frame and a 40-bit code. With these values it can reach the following cases:

- a header followed by a data group of all ones, giving a 13-bit run of ones;
- failures at the first row, at a row whose data bit was flipped, at the column field and at the stop bit, each checked for the exact cycle of its pulse;
- a run of 8 ones that stops one short of locking;
- resynchronisation from mid-frame.

Confirm mode runs at the same size, so the stored copy is compared across all 40 bits.

// File: rtl/fd_pkg.sv
package fd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT = 2'd0,
    ST_ROWS = 2'd1,
    ST_COLS = 2'd2,
    ST_STOP = 2'd3
  } fd_state_e;
endpackage

// File: rtl/fd_hdr_detect.sv
module fd_hdr_detect #(
  parameter int unsigned HDR_LEN = 9,
  parameter int unsigned CNT_W   = $clog2(HDR_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             strobe_i,
  input  logic             bit_i,
  output logic             found_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  assign found_o = strobe_i && bit_i && (cnt_q == CNT_W'(HDR_LEN - 1));
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else if (strobe_i) begin
      if (!bit_i || found_o) cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fd_frame_parse.sv
module fd_frame_parse
  import fd_pkg::*;
#(
  parameter int unsigned ROWS = 10,
  parameter int unsigned COLS = 4,
  parameter int unsigned ID_W = ROWS * COLS
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic            strobe_i,
  input  logic            bit_i,
  output fd_state_e       state_o,
  output logic            frame_ok_o,
  output logic            fail_o,
  output logic [ID_W-1:0] data_o
);
  localparam int unsigned RW = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam int unsigned PW = $clog2(COLS + 1);

  fd_state_e       state_q;
  logic [RW-1:0]   row_q;
  logic [PW-1:0]   pos_q;
  logic            row_par_q;
  logic [COLS-1:0] col_par_q;
  logic [ID_W-1:0] data_q;

  logic in_frame, at_row_par, row_fail, col_fail, stop_fail, col_exp;

  always_comb begin
    col_exp = 1'b0;
    for (int c = 0; c < COLS; c++) begin
      if (pos_q == PW'(c)) col_exp = col_par_q[c];
    end
  end

  assign in_frame   = strobe_i && (state_q != ST_HUNT);
  assign at_row_par = (pos_q == PW'(COLS));
  assign row_fail   = in_frame && (state_q == ST_ROWS) && at_row_par && (bit_i != row_par_q);
  assign col_fail   = in_frame && (state_q == ST_COLS) && (bit_i != col_exp);
  assign stop_fail  = in_frame && (state_q == ST_STOP) && bit_i;
  assign frame_ok_o = in_frame && (state_q == ST_STOP) && !bit_i;
  assign fail_o     = row_fail || col_fail || stop_fail;
  assign state_o    = state_q;
  assign data_o     = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_HUNT;
      row_q     <= '0;
      pos_q     <= '0;
      row_par_q <= 1'b0;
      col_par_q <= '0;
      data_q    <= '0;
    end else begin
      unique case (state_q)
        ST_HUNT: begin
          if (start_i) begin
            state_q   <= ST_ROWS;
            row_q     <= '0;
            pos_q     <= '0;
            row_par_q <= 1'b0;
            col_par_q <= '0;
          end
        end
        ST_ROWS: begin
          if (strobe_i) begin
            if (!at_row_par) begin
              data_q    <= {data_q[ID_W-2:0], bit_i};
              row_par_q <= row_par_q ^ bit_i;
              for (int c = 0; c < COLS; c++) begin
                if (pos_q == PW'(c)) col_par_q[c] <= col_par_q[c] ^ bit_i;
              end
              pos_q <= pos_q + 1'b1;
            end else if (row_fail) begin
              state_q <= ST_HUNT;
            end else begin
              pos_q     <= '0;
              row_par_q <= 1'b0;
              if (row_q == RW'(ROWS - 1)) state_q <= ST_COLS;
              else                        row_q   <= row_q + 1'b1;
            end
          end
        end
        ST_COLS: begin
          if (strobe_i) begin
            if (col_fail)                      state_q <= ST_HUNT;
            else if (pos_q == PW'(COLS - 1))   state_q <= ST_STOP;
            else                               pos_q   <= pos_q + 1'b1;
          end
        end
        ST_STOP: begin
          if (strobe_i) state_q <= ST_HUNT;
        end
        default: state_q <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/fd_confirm.sv
module fd_confirm #(
  parameter int unsigned ID_W = 40
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            confirm_i,
  input  logic            frame_ok_i,
  input  logic            fail_i,
  input  logic [ID_W-1:0] data_i,
  output logic [ID_W-1:0] id_o,
  output logic            id_valid_o
);
  logic [ID_W-1:0] last_q, id_q;
  logic            have_q, vld_q, report;

  // compare against the previous good frame only when confirm mode is on
  assign report = !confirm_i || (have_q && (last_q == data_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      id_q   <= '0;
      have_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= 1'b0;
      if (frame_ok_i) begin
        last_q <= data_i;
        have_q <= 1'b1;
        if (report) begin
          id_q  <= data_i;
          vld_q <= 1'b1;
        end
      end else if (fail_i) begin
        have_q <= 1'b0;
      end
    end
  end

  assign id_o       = id_q;
  assign id_valid_o = vld_q;
endmodule

// File: rtl/fd_frame_decoder.sv
module fd_frame_decoder
  import fd_pkg::*;
#(
  parameter int unsigned HDR_LEN = 9,
  parameter int unsigned ROWS    = 10,
  parameter int unsigned COLS    = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 bit_i,
  input  logic                 bit_valid_i,
  input  logic                 confirm_i,
  output logic [ROWS*COLS-1:0] id_o,
  output logic                 id_valid_o,
  output logic                 parity_err_o
);
  localparam int unsigned ID_W  = ROWS * COLS;
  localparam int unsigned CNT_W = $clog2(HDR_LEN + 1);

  fd_state_e        state;
  logic [CNT_W-1:0] ones_cnt;
  logic             hunting, hdr_found, frame_ok, fail;
  logic [ID_W-1:0]  data;
  logic             parity_err_q;

  assign hunting = (state == ST_HUNT);

  fd_hdr_detect #(
    .HDR_LEN (HDR_LEN),
    .CNT_W   (CNT_W)
  ) u_hdr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (!hunting),
    .strobe_i (bit_valid_i && hunting),
    .bit_i    (bit_i),
    .found_o  (hdr_found),
    .cnt_o    (ones_cnt)
  );

  fd_frame_parse #(
    .ROWS (ROWS),
    .COLS (COLS),
    .ID_W (ID_W)
  ) u_parse (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (hdr_found),
    .strobe_i   (bit_valid_i),
    .bit_i      (bit_i),
    .state_o    (state),
    .frame_ok_o (frame_ok),
    .fail_o     (fail),
    .data_o     (data)
  );

  fd_confirm #(
    .ID_W (ID_W)
  ) u_confirm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .confirm_i  (confirm_i),
    .frame_ok_i (frame_ok),
    .fail_i     (fail),
    .data_i     (data),
    .id_o       (id_o),
    .id_valid_o (id_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) parity_err_q <= 1'b0;
    else         parity_err_q <= fail;
  end

  assign parity_err_o = parity_err_q;
endmodule

// File: rtl/fd_frame_decoder_chk.sv
module fd_frame_decoder_chk
  import fd_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             bit_i,
  input logic             bit_valid_i,
  input logic             id_valid_o,
  input logic             parity_err_o,
  input fd_state_e        state,
  input logic [CNT_W-1:0] ones_cnt
);
  // R4: a failure pulse always follows a strobed bit
  a_r4_err_after_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> $past(bit_valid_i));

  // R4: after a failure the decoder is back in header search
  a_r4_err_back_to_hunt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    parity_err_o |-> (state == ST_HUNT));

  // R7: a report follows a stop strobe carrying 0
  a_r7_valid_after_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    id_valid_o |-> $past((state == ST_STOP) && bit_valid_i && !bit_i));

  // R7: report and failure never coincide
  a_r7_valid_excl_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(id_valid_o && parity_err_o));

  // R2: a strobed zero while hunting clears the run count
  a_r2_zero_clears_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state == ST_HUNT) && bit_valid_i && !bit_i) |=> (ones_cnt == '0));

  // R2: the run count stays clear outside header search
  a_r2_cnt_idle_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state != ST_HUNT) |-> (ones_cnt == '0));

  // R9: idle cycles leave the decoder state untouched
  a_r9_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_i |=> ($stable(state) && $stable(ones_cnt)));
endmodule

bind fd_frame_decoder fd_frame_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .bit_i        (bit_i),
  .bit_valid_i  (bit_valid_i),
  .id_valid_o   (id_valid_o),
  .parity_err_o (parity_err_o),
  .state        (state),
  .ones_cnt     (ones_cnt)
);

// File: tb/tb_fd_frame_decoder.sv
module tb_fd_frame_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_d = 1'b0;
  logic        bit_valid = 1'b0;
  logic        confirm = 1'b0;
  logic [39:0] id;
  logic        id_valid, perr;

  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 1'b0;

  logic [39:0] exp_id_q[$];
  string       exp_id_tag[$];
  string       exp_err_tag[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  fd_frame_decoder dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bit_i        (bit_d),
    .bit_valid_i  (bit_valid),
    .confirm_i    (confirm),
    .id_o         (id),
    .id_valid_o   (id_valid),
    .parity_err_o (perr)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference frame built from the layout in the requirements; bit 63 goes first
  function automatic logic [63:0] mk_frame(input logic [39:0] v);
    logic [63:0] f;
    logic [3:0]  cp;
    f  = '0;
    cp = '0;
    for (int k = 0; k < 9; k++) f = {f[62:0], 1'b1};
    for (int r = 0; r < 10; r++) begin
      logic [3:0] n;
      n = v[39-4*r -: 4];
      for (int c = 0; c < 4; c++) f = {f[62:0], n[3-c]};
      f  = {f[62:0], ^n};
      cp = cp ^ n;
    end
    for (int c = 0; c < 4; c++) f = {f[62:0], cp[3-c]};
    f = {f[62:0], 1'b0};
    return f;
  endfunction

  task automatic push_id(input logic [39:0] v, input string tag);
    exp_id_q.push_back(v);
    exp_id_tag.push_back(tag);
  endtask

  task automatic send_frame(input logic [39:0] v, input int flip, input int err_pos,
                            input bit gap, input int first, input string tag);
    logic [63:0] f;
    f = mk_frame(v);
    if (flip >= 0) f[63-flip] = ~f[63-flip];
    for (int i = first; i < 64; i++) begin
      bit_d     = f[63-i];
      bit_valid = 1'b1;
      @(negedge clk);
      if (i == err_pos)
        check(perr == 1'b1, tag, "error pulse cycle", {63'b0, perr}, 64'd1);
      if (gap) begin
        bit_valid = 1'b0;
        bit_d     = ~bit_d;
        @(negedge clk);
      end
    end
    bit_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    bit_d     = b;
    bit_valid = 1'b1;
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    bit_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(id_valid == 1'b0, "R1", "id_valid_o in reset", {63'b0, id_valid}, 64'd0);
    check(perr == 1'b0, "R1", "parity_err_o in reset", {63'b0, perr}, 64'd0);
    check(id == 40'd0, "R1", "id_o in reset", {24'b0, id}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    check(exp_id_q.size() == 0, tag, "missing id reports",
          64'(exp_id_q.size()), 64'd0);
    check(exp_err_tag.size() == 0, tag, "missing error pulses",
          64'(exp_err_tag.size()), 64'd0);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (id_valid) begin
        if (exp_id_q.size() == 0) begin
          check(1'b0, "R7", "unexpected id_valid_o", {24'b0, id}, 64'd0);
        end else begin
          logic [39:0] e;
          string       t;
          e = exp_id_q.pop_front();
          t = exp_id_tag.pop_front();
          check(id == e, t, "id_o", {24'b0, id}, {24'b0, e});
        end
      end
      if (perr) begin
        if (exp_err_tag.size() == 0) begin
          check(1'b0, "R4", "unexpected parity_err_o", 64'd1, 64'd0);
        end else begin
          string t;
          t = exp_err_tag.pop_front();
          check(1'b1, t, "parity_err_o", 64'd1, 64'd1);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  localparam logic [39:0] ID_A = 40'h12_3456_789A;
  localparam logic [39:0] ID_B = 40'hA5_0F0F_C3E1;
  localparam logic [39:0] ID_C = 40'hFF_FFFF_FFFF;
  localparam logic [39:0] ID_D = 40'h00_0000_0000;
  localparam logic [39:0] ID_E = 40'h5A_C396_0F1E;

  initial begin
    do_reset();

    // R3 / R8: back-to-back frames, including an all-ones body
    push_id(ID_A, "R3");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R3");
    push_id(ID_B, "R8");
    send_frame(ID_B, -1, -1, 1'b0, 0, "R8");
    push_id(ID_C, "R8");
    send_frame(ID_C, -1, -1, 1'b0, 0, "R8");
    push_id(ID_D, "R8");
    send_frame(ID_D, -1, -1, 1'b0, 0, "R8");
    drain("R8");
    check(id == ID_D, "R7", "id_o held after report", {24'b0, id}, {24'b0, ID_D});

    // R9: idle cycles with toggling data
    push_id(ID_E, "R9");
    send_frame(ID_E, -1, -1, 1'b1, 0, "R9");
    drain("R9");

    // R4: row parity bit flipped, then recovery (R10)
    exp_err_tag.push_back("R4");
    send_frame(ID_A, 13, 13, 1'b0, 0, "R4");
    push_id(ID_A, "R10");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R10");
    // R4: data bit flipped in row 3, caught at that row's parity bit
    exp_err_tag.push_back("R4");
    send_frame(ID_A, 25, 28, 1'b0, 0, "R4");
    // R5: column parity bit 1 flipped
    exp_err_tag.push_back("R5");
    send_frame(ID_A, 60, 60, 1'b0, 0, "R5");
    push_id(ID_B, "R10");
    send_frame(ID_B, -1, -1, 1'b0, 0, "R10");
    // R6: stop bit set
    exp_err_tag.push_back("R6");
    send_frame(ID_A, 63, 63, 1'b0, 0, "R6");
    push_id(ID_A, "R10");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R10");
    drain("R10");

    // R2: eight ones then a zero must not leave a partial run behind
    send_bit(1'b0);
    for (int k = 0; k < 8; k++) send_bit(1'b1);
    send_bit(1'b0);
    push_id(ID_B, "R2");
    send_frame(ID_B, -1, -1, 1'b0, 0, "R2");
    drain("R2");

    // R12: start in the middle of a frame
    do_reset();
    send_frame(ID_A, -1, -1, 1'b0, 20, "R12");
    push_id(ID_D, "R12");
    send_frame(ID_D, -1, -1, 1'b0, 0, "R12");
    drain("R12");

    // R11: confirm mode
    confirm = 1'b1;
    do_reset();
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    push_id(ID_A, "R11");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    send_frame(ID_B, -1, -1, 1'b0, 0, "R11");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    push_id(ID_A, "R11");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    exp_err_tag.push_back("R11");
    send_frame(ID_A, 13, 13, 1'b0, 0, "R11");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    push_id(ID_A, "R11");
    send_frame(ID_A, -1, -1, 1'b0, 0, "R11");
    drain("R11");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end
endmodule